// File: doc/BRIEF.md
# Key-Protected Fault Injection Controller

This block is a single memory-mapped control word that lets software deliberately corrupt a peripheral's safety-monitored control bits, so that the peripheral's self-diagnostics can be exercised. Each write must carry a 24-bit access key in its upper bits. A write with the wrong key is dropped whole. A write with the right key can force faults onto six protected control bits or request a configuration-parity fault. It can also set a one-way lock that freezes the register until the next hardware reset.

The block watches three status inputs: receiver active, transmitter active, and an external parity-error flag. It drives six registered fault-force lines and a one-cycle configuration-parity fault pulse. It also drives three sticky flags: parity error, static-data error and write error. The reconfiguration logic clears the parity fault with a dedicated pulse. A separate status-clear pulse, which stands in for a status read, clears the write-error and static-data-error flags.

Top module: `fault_inject_ctrl`

## Requirements
- R1: After hardware reset, all six force outputs, the parity-fault pulse, all three flags and the whole read word are 0.
- R2: A write whose bits 31:8 differ from 24'h494649 changes nothing: the force outputs, the flags, the pulse and the lock all keep their values.
- R3: A write with the correct key and bit 7 = 1 that passes the R4 conditions sets the lock. While the lock is set, every later write has no effect, including a write of zero. Only hardware reset releases it.
- R4: A lock request is refused when any of these is true: bits 6:0 of the written word are nonzero, any force output is currently 1, or the parity-error output is 1. The other fields of that write still apply.
- R5: The read word shows the lock state in bit 7 and 0 in every other bit.
- R6: On an accepted write, the force outputs take bits 5:0 of the written data on the next clock edge. Bit 0 drives the receiver-enable target, bit 1 clock enable, bit 2 transmitter enable, bit 3 receiver direct access, bit 4 transmitter direct access and bit 5 write-protect enable. Writing 0 to a bit removes that fault.
- R7: An accepted write with any of bits 5:0 at 1 sets both the write-error flag and the static-data-error flag. Both flags then stay set.
- R8: An accepted write with bit 6 = 1 while the receiver and transmitter are both inactive produces a one-cycle parity-fault pulse and sets the sticky parity-error flag and the write-error flag. If either of them is active, the parity request is ignored.
- R9: The clear-parity input clears the sticky parity-error flag. If it arrives in the same cycle as an accepted parity fault, the set wins.
- R10: The status-clear input clears the write-error and static-data-error flags. If it arrives in the same cycle as a new set, the set wins.
- R11: The parity-error output is also 1 whenever the external parity-error input is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write word: key in 31:8, lock 7, parity request 6, forces 5:0 |
| rd_data | output | 32 | Read word; only bit 7 (lock) can be nonzero |
| rx_active | input | 1 | Receiver of the protected engine is enabled |
| tx_active | input | 1 | Transmitter of the protected engine is enabled |
| parity_err_in | input | 1 | Parity-error flag from the protected engine |
| parity_clr | input | 1 | One-cycle pulse from reconfiguration logic that clears the parity fault |
| status_clr | input | 1 | One-cycle pulse that clears the write-error and static-data-error flags |
| force_o | output | 6 | Per-target fault-force lines |
| cfg_parity_fault_o | output | 1 | One-cycle configuration-parity fault pulse |
| parity_err_o | output | 1 | Sticky parity-error flag, ORed with the external flag |
| sde_flag_o | output | 1 | Sticky static-data-error flag |
| werr_flag_o | output | 1 | Sticky write-error flag |

## Verification
The assertions check, on every cycle, the properties that hold at every clock edge:
- the lock never drops once set;
- a write with the wrong key, or any write while locked, leaves the force lines unchanged;
- a parity pulse appears only after a cycle in which both engine directions were idle;
- an accepted force write always raises the static-data-error flag.

Only the bench's scenarios can show the following:
- the exact mapping of each force bit;
- the several reasons a lock request is refused;
- the set-over-clear priorities of the flags;
- the release of the lock by a hardware reset.

// File: rtl/fi_pkg.sv
package fi_pkg;
    localparam int DATA_W     = 32;
    localparam int KEY_W      = 24;
    localparam int NUM_FORCE  = 6;
    localparam logic [KEY_W-1:0] ACCESS_KEY = 24'h494649;
    localparam int LOCK_BIT   = 7;
    localparam int PARITY_BIT = 6;
    localparam int KEY_LSB    = DATA_W - KEY_W;

    typedef struct packed {
        logic                 accept;
        logic                 lock_req;
        logic                 parity_req;
        logic [NUM_FORCE-1:0] force_val;
    } fi_cmd_t;
endpackage

// File: rtl/fi_key_gate.sv
module fi_key_gate
    import fi_pkg::*;
(
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              locked,
    output fi_cmd_t           cmd
);
    logic key_match;

    always_comb begin
        key_match      = (wr_data[DATA_W-1:KEY_LSB] == ACCESS_KEY);
        cmd.accept     = wr_en && key_match && !locked;
        cmd.lock_req   = wr_data[LOCK_BIT];
        cmd.parity_req = wr_data[PARITY_BIT];
        cmd.force_val  = wr_data[NUM_FORCE-1:0];
    end
endmodule

// File: rtl/fi_force_bank.sv
module fi_force_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] load_val,
    output logic [N-1:0] force_q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic bit_d;
        logic bit_q;

        always_comb begin
            bit_d = bit_q;
            if (load) bit_d = load_val[i];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= bit_d;
        end

        assign force_q[i] = bit_q;
    end
endmodule

// File: rtl/fi_flag_unit.sv
module fi_flag_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_werr,
    input  logic set_sde,
    input  logic set_par,
    input  logic clr_status,
    input  logic clr_par,
    output logic werr_q,
    output logic sde_q,
    output logic par_q
);
    typedef struct packed {
        logic werr;
        logic sde;
        logic par;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_status) begin
            st_d.werr = 1'b0;
            st_d.sde  = 1'b0;
        end
        if (clr_par)  st_d.par  = 1'b0;
        if (set_werr) st_d.werr = 1'b1;
        if (set_sde)  st_d.sde  = 1'b1;
        if (set_par)  st_d.par  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign werr_q = st_q.werr;
    assign sde_q  = st_q.sde;
    assign par_q  = st_q.par;

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_werr && clr_status) |=> werr_q);
    a_r9_par_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_par && clr_par) |=> par_q);
endmodule

// File: rtl/fault_inject_ctrl.sv
module fault_inject_ctrl
    import fi_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 rx_active,
    input  logic                 tx_active,
    input  logic                 parity_err_in,
    input  logic                 parity_clr,
    input  logic                 status_clr,
    output logic [NUM_FORCE-1:0] force_o,
    output logic                 cfg_parity_fault_o,
    output logic                 parity_err_o,
    output logic                 sde_flag_o,
    output logic                 werr_flag_o
);
    typedef struct packed {
        logic lock;
        logic pulse;
    } ctl_t;

    ctl_t    ctl_d, ctl_q;
    fi_cmd_t cmd;
    logic    par_q;
    logic    par_ok, force_hit, lock_ok;

    fi_key_gate u_gate (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .locked  (ctl_q.lock),
        .cmd     (cmd)
    );

    fi_force_bank #(.N(NUM_FORCE)) u_force (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cmd.accept),
        .load_val (cmd.force_val),
        .force_q  (force_o)
    );

    always_comb begin
        par_ok    = cmd.accept && cmd.parity_req && !rx_active && !tx_active;
        force_hit = cmd.accept && (cmd.force_val != '0);
        lock_ok   = cmd.accept && cmd.lock_req && !cmd.parity_req
                    && (cmd.force_val == '0) && (force_o == '0)
                    && !parity_err_o;
        ctl_d       = ctl_q;
        ctl_d.pulse = par_ok;
        if (lock_ok) ctl_d.lock = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    fi_flag_unit u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_werr   (force_hit || par_ok),
        .set_sde    (force_hit),
        .set_par    (par_ok),
        .clr_status (status_clr),
        .clr_par    (parity_clr),
        .werr_q     (werr_flag_o),
        .sde_q      (sde_flag_o),
        .par_q      (par_q)
    );

    always_comb begin
        rd_data           = '0;
        rd_data[LOCK_BIT] = ctl_q.lock;
    end

    assign cfg_parity_fault_o = ctl_q.pulse;
    assign parity_err_o       = par_q || parity_err_in;

    // R3: the lock never falls once it is set
    a_r3_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[LOCK_BIT] |=> rd_data[LOCK_BIT]);
    // R3: while locked, no write moves the force lines
    a_r3_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[LOCK_BIT] && wr_en) |=> $stable(force_o));
    // R2: a wrong key leaves the force lines and the lock alone
    a_r2_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[DATA_W-1:KEY_LSB] != ACCESS_KEY)
        |=> ($stable(force_o) && $stable(rd_data)));
    // R8: a parity pulse follows only a cycle with the engine idle
    a_r8_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_parity_fault_o |-> $past(!rx_active && !tx_active));
    // R7: an accepted force write raises the static-data-error flag
    a_r7_sde_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[DATA_W-1:KEY_LSB] == ACCESS_KEY
         && !rd_data[LOCK_BIT] && wr_data[NUM_FORCE-1:0] != '0)
        |=> (sde_flag_o && werr_flag_o));
    // R4: the lock rises only from a state with no pending fault
    a_r4_lock_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[LOCK_BIT]) |-> (force_o == '0));
endmodule

// File: tb/sim_fault_inject_ctrl.sv
module sim_fault_inject_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        rx_active = 1'b0;
    logic        tx_active = 1'b0;
    logic        parity_err_in = 1'b0;
    logic        parity_clr = 1'b0;
    logic        status_clr = 1'b0;
    logic [5:0]  force_o;
    logic        cfg_parity_fault_o, parity_err_o, sde_flag_o, werr_flag_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam logic [23:0] KEY = 24'h494649;

    always #10 clk = ~clk;

    fault_inject_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .rx_active(rx_active), .tx_active(tx_active),
        .parity_err_in(parity_err_in), .parity_clr(parity_clr),
        .status_clr(status_clr), .force_o(force_o),
        .cfg_parity_fault_o(cfg_parity_fault_o), .parity_err_o(parity_err_o),
        .sde_flag_o(sde_flag_o), .werr_flag_o(werr_flag_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_write(input logic [23:0] key, input logic [7:0] low);
        @(negedge clk); wr_en = 1'b1; wr_data = {key, low};
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic clr_status();
        @(negedge clk); status_clr = 1'b1;
        @(negedge clk); status_clr = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 force", {26'd0, force_o}, 32'd0);
        check("R1 flags", {28'd0, cfg_parity_fault_o, parity_err_o, sde_flag_o, werr_flag_o}, 32'd0);
        check("R1 rd", rd_data, 32'd0);
    endtask

    task automatic t_bad_key();
        do_write(24'h494648, 8'h3F);
        check("R2 force", {26'd0, force_o}, 32'd0);
        check("R2 werr", {31'd0, werr_flag_o}, 32'd0);
        do_write(24'h000000, 8'h80);
        check("R2 lock", rd_data, 32'd0);
    endtask

    task automatic t_force_map();
        for (int i = 0; i < 6; i++) begin
            do_write(KEY, 8'(1 << i));
            check("R6 map", {26'd0, force_o}, 32'(1 << i));
            check("R5 rd", rd_data, 32'd0);
        end
        check("R7 werr", {31'd0, werr_flag_o}, 32'd1);
        check("R7 sde", {31'd0, sde_flag_o}, 32'd1);
        do_write(KEY, 8'h00);
        check("R6 clear", {26'd0, force_o}, 32'd0);
        check("R7 sticky", {30'd0, sde_flag_o, werr_flag_o}, 32'd3);
    endtask

    task automatic t_status();
        clr_status();
        check("R10 clear", {30'd0, sde_flag_o, werr_flag_o}, 32'd0);
        @(negedge clk); wr_en = 1'b1; wr_data = {KEY, 8'h04}; status_clr = 1'b1;
        @(negedge clk); wr_en = 1'b0; wr_data = '0; status_clr = 1'b0;
        check("R10 set wins", {30'd0, sde_flag_o, werr_flag_o}, 32'd3);
        do_write(KEY, 8'h00);
        clr_status();
    endtask

    task automatic t_parity_busy();
        rx_active = 1'b1;
        do_write(KEY, 8'h40);
        check("R8 rx busy", {29'd0, cfg_parity_fault_o, parity_err_o, werr_flag_o}, 32'd0);
        rx_active = 1'b0; tx_active = 1'b1;
        do_write(KEY, 8'h40);
        check("R8 tx busy", {29'd0, cfg_parity_fault_o, parity_err_o, werr_flag_o}, 32'd0);
        tx_active = 1'b0;
    endtask

    task automatic t_parity_idle();
        do_write(KEY, 8'h40);
        check("R8 pulse", {29'd0, cfg_parity_fault_o, parity_err_o, werr_flag_o}, 32'd7);
        @(negedge clk);
        check("R8 one cycle", {30'd0, cfg_parity_fault_o, parity_err_o}, 32'd1);
        do_write(KEY, 8'h80);
        check("R4 par blocks lock", rd_data, 32'd0);
        @(negedge clk); parity_clr = 1'b1;
        @(negedge clk); parity_clr = 1'b0;
        check("R9 clear", {31'd0, parity_err_o}, 32'd0);
        @(negedge clk); wr_en = 1'b1; wr_data = {KEY, 8'h40}; parity_clr = 1'b1;
        @(negedge clk); wr_en = 1'b0; wr_data = '0; parity_clr = 1'b0;
        check("R9 set wins", {31'd0, parity_err_o}, 32'd1);
        @(negedge clk); parity_clr = 1'b1;
        @(negedge clk); parity_clr = 1'b0;
        clr_status();
    endtask

    task automatic t_ext_parity();
        parity_err_in = 1'b1;
        @(negedge clk);
        check("R11 ext", {31'd0, parity_err_o}, 32'd1);
        do_write(KEY, 8'h80);
        check("R11 blocks lock", rd_data, 32'd0);
        parity_err_in = 1'b0;
    endtask

    task automatic t_lock_refused();
        do_write(KEY, 8'h81);
        check("R4 data bits", rd_data, 32'd0);
        check("R4 rest applies", {26'd0, force_o}, 32'd1);
        do_write(KEY, 8'h02);
        do_write(KEY, 8'h80);
        check("R4 pending force", rd_data, 32'd0);
        check("R4 force cleared", {26'd0, force_o}, 32'd0);
        clr_status();
    endtask

    task automatic t_lock();
        do_write(KEY, 8'h80);
        check("R3 locked", rd_data, 32'h80);
        do_write(KEY, 8'h3F);
        check("R3 no force", {26'd0, force_o}, 32'd0);
        check("R3 no flag", {30'd0, sde_flag_o, werr_flag_o}, 32'd0);
        do_write(KEY, 8'h00);
        check("R3 zero write", rd_data, 32'h80);
        do_write(KEY, 8'h40);
        check("R3 no parity", {30'd0, cfg_parity_fault_o, parity_err_o}, 32'd0);
        do_reset();
        check("R3 reset release", rd_data, 32'd0);
        do_write(KEY, 8'h01);
        check("R3 writable", {26'd0, force_o}, 32'd1);
    endtask

    initial begin
        t_reset();
        t_bad_key();
        t_force_map();
        t_status();
        t_parity_busy();
        t_parity_idle();
        t_ext_parity();
        t_lock_refused();
        t_lock();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule